// File: doc/BRIEF.md
# Shifting literal data latch

This block holds the 37-bit data word of an instruction dock and loads it in two ways. A capture strobe replaces the whole word with a value from the data path. A literal instruction writes its 17-bit payload into the low 17 bits of the word. A 2-bit fill mode sets the upper 20 bits of the word during a literal.

The fill modes are shift, zero-fill and one-fill. In shift mode the old low 20 bits move into the upper field, so a constant wider than one payload is built by several literals in a row. Zero-fill and one-fill start a new constant with a known sign extension.

A literal only takes effect when its predicate holds. A literal that belongs to an outer loop also needs a live (non-zero) outer-loop count. Every change to the word gives a one-cycle "updated" pulse, which rises in the same cycle as the new word.

Top module: `lit_data_latch`

## Requirements
- R1: While reset is asserted, and after it is released, `word_o` is all zeros and `upd_o` is 0 until the first load.
- R2: When `cap_stb_i` is 1 at a clock edge, `word_o` equals `cap_word_i` after that edge.
- R3: When a capture and an executing literal fall in the same cycle, the capture wins and the literal has no effect.
- R4: An executing literal with fill code 00, 01 or 10 places `lit_pay_i` in `word_o[16:0]`.
- R5: Fill code 00 (shift) loads `word_o[36:17]` with the previous `word_o[19:0]`.
- R6: Fill code 01 (zero-fill) clears `word_o[36:17]`.
- R7: Fill code 10 (one-fill) sets every bit of `word_o[36:17]`.
- R8: Fill code 11 is reserved. A literal carrying it leaves `word_o` unchanged and gives no pulse.
- R9: A literal with `pred_ok_i` = 0 leaves `word_o` unchanged and gives no pulse.
- R10: A literal with `one_shot_i` = 0 and `outer_live_i` = 0 is ignored. A literal with `one_shot_i` = 1 executes whatever the value of `outer_live_i`.
- R11: `upd_o` is 1 for exactly the cycle after each edge that loads the word, and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cap_stb_i | input | 1 | Capture strobe that loads the full word |
| cap_word_i | input | 37 | Word loaded on a capture |
| lit_req_i | input | 1 | A literal instruction is presented this cycle |
| lit_fill_i | input | 2 | Fill mode: 00 shift, 01 zero, 10 ones, 11 reserved |
| lit_pay_i | input | 17 | Literal payload |
| pred_ok_i | input | 1 | The literal's predicate is true |
| one_shot_i | input | 1 | The literal is not part of an outer loop |
| outer_live_i | input | 1 | The outer-loop count is above zero |
| word_o | output | 37 | Latched data word |
| upd_o | output | 1 | One-cycle pulse after each load |

## Verification
Literals are run with each fill code on top of a known captured word. Two shift literals in a row show that the old low field moves up into the upper field and is not simply overwritten. Payloads are chosen with asymmetric bit patterns, so that a swapped field or an off-by-one split shows up in either half of the word. Gated cases vary the predicate, the one-shot flag and the loop-live flag one at a time. The capture-versus-literal collision separates the priority order from a merge of the two sources, and a reserved-code literal tells a no-op apart from a fill.

// File: rtl/lit_latch_pkg.sv
package lit_latch_pkg;
  typedef enum logic [1:0] {
    FILL_SHIFT = 2'b00,
    FILL_ZERO  = 2'b01,
    FILL_ONE   = 2'b10,
    FILL_RSVD  = 2'b11
  } fill_mode_e;
endpackage

// File: rtl/lit_rst_sync.sv
module lit_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/lit_exec_gate.sv
module lit_exec_gate (
  input  logic lit_req_i,
  input  logic pred_ok_i,
  input  logic one_shot_i,
  input  logic outer_live_i,
  output logic fire_o
);
  logic loop_ok;

  always_comb begin
    loop_ok = one_shot_i | outer_live_i;
    fire_o  = lit_req_i & pred_ok_i & loop_ok;
  end
endmodule

// File: rtl/lit_word_merge.sv
module lit_word_merge
  import lit_latch_pkg::*;
#(
  parameter int WORD_W = 37,
  parameter int PAY_W  = 17
) (
  input  logic [WORD_W-1:0] cur_i,
  input  fill_mode_e        mode_i,
  input  logic [PAY_W-1:0]  pay_i,
  output logic [WORD_W-1:0] next_o,
  output logic              valid_o
);
  localparam int HI_W = WORD_W - PAY_W;

  logic [HI_W-1:0] upper;

  always_comb begin
    valid_o = 1'b1;
    case (mode_i)
      FILL_SHIFT: upper = cur_i[HI_W-1:0];
      FILL_ZERO:  upper = '0;
      FILL_ONE:   upper = '1;
      default: begin
        upper   = cur_i[WORD_W-1:PAY_W];
        valid_o = 1'b0;
      end
    endcase
    next_o = {upper, pay_i};
  end
endmodule

// File: rtl/lit_data_latch.sv
module lit_data_latch
  import lit_latch_pkg::*;
#(
  parameter int WORD_W = 37,
  parameter int PAY_W  = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_stb_i,
  input  logic [WORD_W-1:0] cap_word_i,
  input  logic              lit_req_i,
  input  logic [1:0]        lit_fill_i,
  input  logic [PAY_W-1:0]  lit_pay_i,
  input  logic              pred_ok_i,
  input  logic              one_shot_i,
  input  logic              outer_live_i,
  output logic [WORD_W-1:0] word_o,
  output logic              upd_o
);
  localparam int HI_W = WORD_W - PAY_W;

  logic              rst_n;
  logic              lit_fire;
  logic              merge_ok;
  logic [WORD_W-1:0] merged;
  logic [WORD_W-1:0] word_q, word_d;
  logic              upd_q, upd_d;

  lit_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk_i  (clk_i),
    .arst_ni(rst_ni),
    .rst_no (rst_n)
  );

  lit_exec_gate gate_i (
    .lit_req_i   (lit_req_i),
    .pred_ok_i   (pred_ok_i),
    .one_shot_i  (one_shot_i),
    .outer_live_i(outer_live_i),
    .fire_o      (lit_fire)
  );

  lit_word_merge #(.WORD_W(WORD_W), .PAY_W(PAY_W)) merge_i (
    .cur_i  (word_q),
    .mode_i (fill_mode_e'(lit_fill_i)),
    .pay_i  (lit_pay_i),
    .next_o (merged),
    .valid_o(merge_ok)
  );

  // next-state: capture first, then a qualified literal
  always_comb begin
    word_d = word_q;
    upd_d  = 1'b0;
    if (cap_stb_i) begin
      word_d = cap_word_i;
      upd_d  = 1'b1;
    end else if (lit_fire && merge_ok) begin
      word_d = merged;
      upd_d  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      if (upd_d) word_q <= word_d;
      upd_q <= upd_d;
    end
  end

  assign word_o = word_q;
  assign upd_o  = upd_q;

  // one cycle of history after reset release, so $past never reaches into reset
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  // R2
  cap_load_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    live_q && $past(cap_stb_i) |-> word_o == $past(cap_word_i));

  // R4
  pay_low_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    live_q && $past(!cap_stb_i && lit_fire && lit_fill_i != 2'b11)
      |-> word_o[PAY_W-1:0] == $past(lit_pay_i));

  // R5
  shift_up_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    live_q && $past(!cap_stb_i && lit_fire && lit_fill_i == 2'b00)
      |-> word_o[WORD_W-1:PAY_W] == $past(word_o[HI_W-1:0]));

  // R6
  zero_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    live_q && $past(!cap_stb_i && lit_fire && lit_fill_i == 2'b01)
      |-> word_o[WORD_W-1:PAY_W] == '0);

  // R7
  one_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    live_q && $past(!cap_stb_i && lit_fire && lit_fill_i == 2'b10)
      |-> &word_o[WORD_W-1:PAY_W]);

  // R10
  loop_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!one_shot_i && !outer_live_i) |-> !lit_fire);

  // R11
  quiet_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    live_q && !upd_o |-> $stable(word_o));
endmodule

// File: tb/lit_data_latch_tb.sv
module lit_data_latch_tb_top;
  localparam int WORD_W = 37;
  localparam int PAY_W  = 17;
  localparam int HI_W   = WORD_W - PAY_W;

  logic              clk = 1'b0;
  logic              rst_ni;
  logic              cap_stb_i;
  logic [WORD_W-1:0] cap_word_i;
  logic              lit_req_i;
  logic [1:0]        lit_fill_i;
  logic [PAY_W-1:0]  lit_pay_i;
  logic              pred_ok_i, one_shot_i, outer_live_i;
  logic [WORD_W-1:0] word_o;
  logic              upd_o;

  always #5 clk = ~clk;

  lit_data_latch #(.WORD_W(WORD_W), .PAY_W(PAY_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cap_stb_i(cap_stb_i), .cap_word_i(cap_word_i),
    .lit_req_i(lit_req_i), .lit_fill_i(lit_fill_i), .lit_pay_i(lit_pay_i),
    .pred_ok_i(pred_ok_i), .one_shot_i(one_shot_i), .outer_live_i(outer_live_i),
    .word_o(word_o), .upd_o(upd_o)
  );

  typedef struct packed {
    logic              cap;
    logic [WORD_W-1:0] word;
    logic              lit;
    logic [1:0]        fill;
    logic [PAY_W-1:0]  pay;
    logic              pred;
    logic              os;
    logic              live;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 37'h0ABCD1234, 1'b0, 2'b00, 17'h00000, 1'b0, 1'b0, 1'b0},
    '{1'b0, 37'h0,         1'b1, 2'b00, 17'h15A5A, 1'b1, 1'b1, 1'b0},
    '{1'b0, 37'h0,         1'b1, 2'b00, 17'h00F0F, 1'b1, 1'b0, 1'b1},
    '{1'b0, 37'h0,         1'b1, 2'b01, 17'h1FFFF, 1'b1, 1'b0, 1'b1},
    '{1'b0, 37'h0,         1'b1, 2'b10, 17'h00001, 1'b1, 1'b1, 1'b1},
    '{1'b0, 37'h0,         1'b1, 2'b11, 17'h01234, 1'b1, 1'b1, 1'b1},
    '{1'b0, 37'h0,         1'b1, 2'b01, 17'h0AAAA, 1'b0, 1'b1, 1'b1},
    '{1'b0, 37'h0,         1'b1, 2'b10, 17'h05555, 1'b1, 1'b0, 1'b0},
    '{1'b1, 37'h1F0000001, 1'b1, 2'b10, 17'h0F0F0, 1'b1, 1'b1, 1'b1},
    '{1'b0, 37'h0,         1'b0, 2'b00, 17'h00000, 1'b0, 1'b0, 1'b0},
    '{1'b0, 37'h0,         1'b1, 2'b00, 17'h10000, 1'b1, 1'b1, 1'b1},
    '{1'b0, 37'h0,         1'b1, 2'b00, 17'h00003, 1'b1, 1'b0, 1'b1},
    '{1'b0, 37'h0,         1'b0, 2'b00, 17'h00000, 1'b1, 1'b1, 1'b1}
  };

  int total = 0;
  int bad   = 0;
  logic [WORD_W-1:0] exp_q;

  task automatic check(input string req, input logic [WORD_W-1:0] got,
                       input logic [WORD_W-1:0] want);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, got, want);
    end
  endtask

  task automatic drive_idle();
    cap_stb_i = 0; cap_word_i = '0; lit_req_i = 0; lit_fill_i = 2'b00;
    lit_pay_i = '0; pred_ok_i = 0; one_shot_i = 0; outer_live_i = 0;
  endtask

  initial begin
    #1_500_000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    drive_idle();
    rst_ni = 0;
    repeat (3) @(negedge clk);
    // R1: held in reset
    check("R1", word_o, '0);
    check("R1", {36'b0, upd_o}, '0);
    rst_ni = 1;
    repeat (3) @(negedge clk);
    check("R1", word_o, '0);
    check("R1", {36'b0, upd_o}, '0);
    exp_q = '0;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic exp_upd;
      string tag;
      v = VECS[i];
      cap_stb_i = v.cap; cap_word_i = v.word; lit_req_i = v.lit;
      lit_fill_i = v.fill; lit_pay_i = v.pay; pred_ok_i = v.pred;
      one_shot_i = v.os; outer_live_i = v.live;
      exp_upd = 1'b0;
      tag = "R11";
      if (v.cap) begin
        exp_q = v.word; exp_upd = 1'b1;
        tag = v.lit ? "R3" : "R2";
      end else if (v.lit && !v.pred) begin
        tag = "R9";
      end else if (v.lit && !v.os && !v.live) begin
        tag = "R10";
      end else if (v.lit) begin
        case (v.fill)
          2'b00: begin exp_q = {exp_q[HI_W-1:0], v.pay}; exp_upd = 1; tag = "R5"; end
          2'b01: begin exp_q = {{HI_W{1'b0}}, v.pay};    exp_upd = 1; tag = "R6"; end
          2'b10: begin exp_q = {{HI_W{1'b1}}, v.pay};    exp_upd = 1; tag = "R7"; end
          default: tag = "R8";
        endcase
        if (v.os && !v.live && v.fill != 2'b11) tag = "R10";
      end
      @(negedge clk);
      check(tag, word_o, exp_q);
      check("R11", {36'b0, upd_o}, {36'b0, exp_upd});
      if (v.lit && v.pred && (v.os || v.live) && !v.cap && v.fill != 2'b11)
        check("R4", {20'b0, word_o[PAY_W-1:0]}, {20'b0, v.pay});
    end

    // R11: pulse lasts a single cycle
    cap_stb_i = 1; cap_word_i = 37'h123456789;
    @(negedge clk);
    drive_idle();
    @(negedge clk);
    check("R11", {36'b0, upd_o}, '0);
    check("R2", word_o, 37'h123456789);

    // R1: asynchronous reset clears mid-run
    rst_ni = 0;
    #1;
    check("R1", word_o, '0);
    @(negedge clk);
    rst_ni = 1;
    repeat (3) @(negedge clk);
    check("R1", word_o, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule